// File: doc/BRIEF.md
# Tick-Driven Countdown Timer Channel

This block is a single countdown timer channel. It advances only on cycles where an external tick enable is high, normally one pulse per microsecond. Software programs it through two 32-bit registers. The control word holds three fields: a run flag, a repeat flag and a 29-bit reload count. The status word reports the live count and a pending-event flag that software clears by writing a one to it.

To get an expiry after N ticks, software writes N-1 as the reload count. When the count reaches zero and the next tick arrives, the channel sets its pending flag. It then does one of two things. In repeat mode it reloads the stored count on that same tick and keeps running. In single-shot mode it clears its own run flag and stops at zero. The interrupt output is a level that stays high for as long as the pending flag is set.

Top module: `tick_countdown_timer`

## Requirements
- R1: After a synchronous active-low reset, both registers read as zero and `irq` is low. Ticks that arrive before any control write leave the count at zero and raise no event.
- R2: A write to the control word (byte offset 0x0) captures the run flag from bit 31, the repeat flag from bit 30 and the reload count from bits [28:0]. Reading the control word returns those fields in the same positions, with all other bits zero. When bit 31 of the write is set, the count takes the new reload value on the clock edge of the write.
- R3: While the channel is running and the count is nonzero, each tick lowers the count by exactly one. Cycles without a tick leave the count unchanged.
- R4: With a reload value of N-1, the pending flag and `irq` go high on the Nth tick after the control write. A reload value of 0 therefore fires on the first tick.
- R5: In single-shot mode (bit 30 clear), an expiry clears the run flag and the count stays at zero. Later ticks raise no further event.
- R6: In repeat mode (bit 30 set), an expiry reloads the stored reload value on the same tick, and the run flag stays set.
- R7: Writing the control word with bit 31 clear (for example, writing 0) stops the countdown. The count then holds its value through later ticks.
- R8: Reading the status word (byte offset 0x4) returns the count in bits [28:0] and the pending flag in bit 30. Every other bit reads as zero.
- R9: Writing the status word with bit 30 set clears the pending flag and drops `irq`. A write with bit 30 clear has no effect. No write to the status word changes the count.
- R10: If an expiry and a pending-flag clear fall on the same cycle, the pending flag ends up set.
- R11: If a control-word write and a tick fall on the same cycle, the write takes effect and the tick is discarded. That tick neither decrements the count nor causes an expiry.
- R12: Rewriting the control word with bit 31 set while a countdown is in progress restarts the countdown from the newly written reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable pulse; the counter moves only when this is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register being read or written |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at `addr` (combinational) |
| irq | output | 1 | Level-high interrupt; high while the pending flag is set |

## Verification
Two pairs of functions can fall on the same cycle, and each pair has its own rule:
- Expiry and software clear: the bench programs a zero reload value so that the very next tick expires. It raises that tick in the same cycle as a status-word write that clears the pending flag. The expected result is that the flag stays set.
- Control write and tick: the bench places a control-word write on a tick cycle at two points, once mid-countdown and once at count zero. The expected result is that the count equals the newly written value and that no expiry is recorded.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the tick countdown timer.
// Assumes a 32-bit register bus and a counter of at most 29 bits.
package tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 29;
    localparam int RUN_POS  = 31;
    localparam int REP_POS  = 30;
    localparam int PEND_POS = 30;

    typedef struct packed {
        logic             run;
        logic             rep;
        logic [CNT_W-1:0] reload;
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_ctrl_reg.sv
// Control register: holds the run flag, the repeat flag and the reload count.
// Assumes the decoded write word arrives already split into fields.
// A single-shot expiry clears the run flag unless a write lands in the same cycle.
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_ctrl,
    input  tmr_ctrl_t new_ctrl,
    input  logic      expire,
    output tmr_ctrl_t ctrl
);

    // Capture software writes, and self-stop after a single-shot expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= new_ctrl;
        end else if (expire && !ctrl.rep) begin
            ctrl.run <= 1'b0;
        end
    end

    // R2
    ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ctrl == $past(new_ctrl));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl.rep) |=> !ctrl.run);

    // R6
    repeat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl.rep) |=> ctrl.run);

endmodule

// File: rtl/tmr_down_counter.sv
// Countdown core: loads on a start write and decrements on each tick while running.
// When the count is zero, the next tick is an expiry; repeat mode reloads on that tick.
// Assumes `hold` marks a control write cycle, during which the tick is discarded.
module tmr_down_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             rep,
    input  logic             hold,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic step;

    // A tick counts only while running and outside a control write cycle.
    always_comb begin
        step   = tick && run && !hold;
        expire = step && (count == '0);
    end

    // Load, decrement or reload the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_now) begin
            count <= load_val;
        end else if (step) begin
            if (count == '0) begin
                if (rep) begin
                    count <= reload_val;
                end
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    // R3
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !hold && count != '0) |=> count == $past(count) - 1'b1);

    // R6
    rep_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rep) |=> count == $past(reload_val));

    // R7
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_now && (!tick || !run || hold)) |=> $stable(count));

    // R12
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> count == $past(load_val));

endmodule

// File: rtl/tmr_pend_flag.sv
// Pending-event flag: set by an expiry, cleared by software.
// A set in the same cycle as a clear wins, so no event is lost.
module tmr_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pending
);

    // Hold the pending flag; a set takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (set) begin
            pending <= 1'b1;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end

    // R10
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> pending);

    // R9
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !pending);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(pending));

endmodule

// File: rtl/tmr_read_mux.sv
// Read-data selector: forms the control and status words and picks one by offset.
// Assumes a combinational read path; unmapped offsets read zero.
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h4
) (
    input  logic [ADDR_W-1:0] addr,
    input  tmr_ctrl_t         ctrl,
    input  logic [CNT_W-1:0]  count,
    input  logic              pending,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] stat_word;

    // Lay out both words with their fields at fixed positions.
    always_comb begin
        ctrl_word              = '0;
        ctrl_word[CNT_W-1:0]   = ctrl.reload;
        ctrl_word[RUN_POS]     = ctrl.run;
        ctrl_word[REP_POS]     = ctrl.rep;
        stat_word              = '0;
        stat_word[CNT_W-1:0]   = count;
        stat_word[PEND_POS]    = pending;
    end

    // Select by byte offset.
    always_comb begin
        if (addr == CTRL_OFS) begin
            rdata = ctrl_word;
        end else if (addr == STAT_OFS) begin
            rdata = stat_word;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/tick_countdown_timer.sv
// Top level of one tick-driven countdown timer channel.
// Decodes register writes, wires up the control register, the counter, the
// pending flag and the read selector, and drives the level interrupt.
// Assumes `tick` is a single-cycle enable that comes from a prescaler outside this block.
module tick_countdown_timer
    import tmr_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic             wr_ctrl;
    logic             wr_stat;
    logic             load_now;
    logic             clr_pend;
    logic             expire;
    logic             pending;
    logic [CNT_W-1:0] count;
    tmr_ctrl_t        new_ctrl;
    tmr_ctrl_t        ctrl;
    logic             unused_rsvd;

    // Decode writes and split the control word into its fields.
    always_comb begin
        wr_ctrl         = wr_en && (addr == CTRL_OFS);
        wr_stat         = wr_en && (addr == STAT_OFS);
        new_ctrl.run    = wdata[RUN_POS];
        new_ctrl.rep    = wdata[REP_POS];
        new_ctrl.reload = wdata[CNT_W-1:0];
        load_now        = wr_ctrl && wdata[RUN_POS];
        clr_pend        = wr_stat && wdata[PEND_POS];
    end

    assign unused_rsvd = ^wdata[RUN_POS-2:CNT_W];

    tmr_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .new_ctrl (new_ctrl),
        .expire   (expire),
        .ctrl     (ctrl)
    );

    tmr_down_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .run        (ctrl.run),
        .rep        (ctrl.rep),
        .hold       (wr_ctrl),
        .load_now   (load_now),
        .load_val   (new_ctrl.reload),
        .reload_val (ctrl.reload),
        .count      (count),
        .expire     (expire)
    );

    tmr_pend_flag u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (expire),
        .clr     (clr_pend),
        .pending (pending)
    );

    tmr_read_mux #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .STAT_OFS (STAT_OFS)
    ) u_rd (
        .addr    (addr),
        .ctrl    (ctrl),
        .count   (count),
        .pending (pending),
        .rdata   (rdata)
    );

    assign irq = pending;

    // R11
    write_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && tick && !wdata[RUN_POS]) |=> $stable(count));

    // R4
    expire_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl.run && !wr_ctrl && count == '0) |=> irq);

endmodule

// File: tb/test_tick_countdown_timer.sv
// Self-checking bench: a vector table walked by one loop, then directed corner cases.
module test_tick_countdown_timer;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        wr_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    tick_countdown_timer i_tick_countdown_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    localparam int NV = 10;
    localparam logic [28:0] V_LOAD [NV] = '{29'd5, 29'd5, 29'd5, 29'd5, 29'd5,
                                            29'd0, 29'd0, 29'd3, 29'd2, 29'h1FFFFFFF};
    localparam logic        V_REP  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
                                            1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam int          V_TCK  [NV] = '{3, 6, 9, 6, 8, 1, 3, 4, 2, 2};
    localparam logic [28:0] V_CNT  [NV] = '{29'd2, 29'd0, 29'd0, 29'd5, 29'd3,
                                            29'd0, 29'd0, 29'd3, 29'd0, 29'h1FFFFFFD};
    localparam logic        V_IRQ  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                                            1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic        V_RUN  [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
                                            1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    localparam logic [31:0] CLR = 32'h4000_0000;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [31:0] cw(input logic run, input logic rep, input logic [28:0] v);
        return {run, rep, 1'b0, v};
    endfunction

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, d); chk("R1 ctrl after reset", d, 32'h0);
        rd(4'h4, d); chk("R1 status after reset", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        ticks(3);
        rd(4'h4, d); chk("R1 ticks before programming", d, 32'h0);

        // Vector table: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            wr(4'h0, 32'h0);
            wr(4'h4, CLR);
            wr(4'h0, cw(1'b1, V_REP[i], V_LOAD[i]));
            ticks(V_TCK[i]);
            rd(4'h4, d);
            chk($sformatf("R3/R4 vec%0d count", i), {3'b0, d[28:0]}, {3'b0, V_CNT[i]});
            chk($sformatf("R4 vec%0d pending", i), {31'b0, d[30]}, {31'b0, V_IRQ[i]});
            chk($sformatf("R4 vec%0d irq pin", i), {31'b0, irq}, {31'b0, V_IRQ[i]});
            rd(4'h0, d);
            chk($sformatf("R5/R6 vec%0d run flag", i), {31'b0, d[31]}, {31'b0, V_RUN[i]});
        end

        // R2 field capture, bit 29 dropped, count loaded immediately
        wr(4'h0, 32'h0); wr(4'h4, CLR);
        wr(4'h0, 32'hE000_0004);
        rd(4'h0, d); chk("R2 ctrl readback", d, 32'hC000_0004);
        rd(4'h4, d); chk("R2 immediate load", d, 32'h0000_0004);

        // R8 full status word layout
        wr(4'h0, 32'h0);
        wr(4'h0, cw(1'b1, 1'b0, 29'd1));
        rd(4'h4, d); chk("R8 status before expiry", d, 32'h0000_0001);
        ticks(2);
        rd(4'h4, d); chk("R8 status after expiry", d, 32'h4000_0000);

        // R9 write with bit 30 clear is ignored, then W1C
        wr(4'h4, 32'hBFFF_FFFF);
        rd(4'h4, d); chk("R9 no-clear write", d, 32'h4000_0000);
        wr(4'h4, CLR);
        rd(4'h4, d); chk("R9 clear write", d, 32'h0);
        chk("R9 irq dropped", {31'b0, irq}, 32'h0);

        // R5 no further events after single-shot expiry
        ticks(5);
        rd(4'h4, d); chk("R5 no re-fire", d, 32'h0);

        // R7 stop holds count
        wr(4'h0, cw(1'b1, 1'b0, 29'd10));
        ticks(3);
        wr(4'h0, 32'h0);
        ticks(4);
        rd(4'h4, d); chk("R7 count frozen", d, 32'h0000_0007);
        rd(4'h0, d); chk("R7 ctrl cleared", d, 32'h0);

        // R12 restart mid countdown
        wr(4'h0, cw(1'b1, 1'b0, 29'd20));
        ticks(2);
        rd(4'h4, d); chk("R12 before restart", d, 32'd18);
        wr(4'h0, cw(1'b1, 1'b0, 29'd9));
        rd(4'h4, d); chk("R12 restart value", d, 32'd9);

        // R11 control write and tick in the same cycle
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 4'h0; wdata = cw(1'b1, 1'b0, 29'd3);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(4'h4, d); chk("R11 write beats tick", d, 32'd3);
        ticks(3);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 4'h0; wdata = 32'h0;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(4'h4, d); chk("R11 no expiry on write cycle", d, 32'h0);

        // R10 expiry and clear in the same cycle
        wr(4'h0, cw(1'b1, 1'b1, 29'd0));
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 4'h4; wdata = CLR;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(4'h4, d); chk("R10 set beats clear", d, 32'h4000_0000);
        chk("R10 irq stays high", {31'b0, irq}, 32'h1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule